// File: doc/BRIEF.md
# Serial Frame Byte Aligner

This block takes one serial receive bit per bit-clock edge from a SONET/SDH line and turns the stream into 8-bit words. Each word comes out with a one-cycle byte strobe, which stands in for a divided byte clock. The byte boundary starts where reset is released. After that it moves only when a downstream framer asks for it by raising its out-of-frame line.

On a rising edge of out-of-frame, the block starts a hunt. It slides an 8-bit window across the stream and looks for a run of twelve 0xF6 framing bytes that all sit at the same bit phase. When it finds such a run, it moves the word boundary onto that phase. The next word it delivers is the byte that follows the run. The block does not check the complete frame pattern; the downstream framer does that.

The output-enable input gates the word and strobe outputs to zero. The bit timing inside the block keeps running while the outputs are gated.

Top module: `frame_byte_aligner`

## Requirements
- R1: Bits are shifted in most-significant bit first, so the first bit received of a word lands in bit 7. After reset is released, the first strobe comes on the 8th bit-clock edge and carries the 8 bits sampled on edges 1 to 8.
- R2: The strobe is one clock wide and comes every 8 edges. The one exception is the single interval that spans a realignment, which lasts from 8 to 15 edges.
- R3: A rising edge on out-of-frame starts a hunt. The hunting flag reads 1 from the edge at which the rise is sampled.
- R4: During a hunt, twelve consecutive 0xF6 bytes at one bit phase cause a lock. The lock clears the hunting flag on the edge that samples the last bit of the twelfth byte. The next strobe, 8 edges later, carries the byte that immediately follows the run.
- R5: A byte other than 0xF6 at a phase restarts the count for that phase. Eleven 0xF6 bytes followed by a different byte do not lock.
- R6: While out-of-frame is low, the word boundary never changes and runs of 0xF6 at other phases are ignored. Sampling out-of-frame low ends any hunt in progress without moving the boundary.
- R7: If out-of-frame stays high after a lock, no new hunt starts until it has gone low and then high again.
- R8: While output-enable is low, the word output reads 0 and the strobe reads 0. Word timing continues, so the first word after output-enable returns high is still on the existing boundary.
- R9: An active-low reset clears the word, the strobe and the hunting flag at once. Any partly assembled word is discarded and the bit count restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock; data is sampled on the rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sdata_i | input | 1 | Serial receive bit |
| oof_i | input | 1 | Out-of-frame request from the downstream framer |
| oe_i | input | 1 | Output enable; low forces the word and strobe outputs to 0 |
| pdata_o | output | 8 | Assembled word, first received bit in bit 7 |
| pstrb_o | output | 1 | One-cycle byte strobe that marks a new word |
| hunting_o | output | 1 | High while a boundary hunt is in progress |

## Verification
The bench builds the block with its default values: 8-bit words, a 0xF6 framing byte and a run length of twelve. At that size a sweep that places the framing run at each of the eight bit offsets in turn is short, and so are the strobe-interval checks across every realignment. Run length twelve also puts the eleven-byte near miss and a hunt dropped halfway through the run within a few hundred cycles. Held out-of-frame, out-of-frame low with a framing run at a foreign phase, gated outputs and reset in the middle of a word are each checked by sending a marker byte afterwards and confirming that it arrives on the expected boundary.

// File: rtl/fba_pkg.sv
package fba_pkg;
  typedef enum logic {
    HS_TRACK = 1'b0,
    HS_HUNT  = 1'b1
  } hunt_state_e;
endpackage

// File: rtl/fba_shift_window.sv
module fba_shift_window #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         bit_i,
  output logic [W-1:0] win_o
);
  logic [W-2:0] hist_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hist_q <= '0;
    else         hist_q <= win_o[W-2:0];
  end

  // window including the bit being sampled at this edge, newest in bit 0
  assign win_o = {hist_q, bit_i};
endmodule

// File: rtl/fba_sync_hunter.sv
module fba_sync_hunter
  import fba_pkg::*;
#(
  parameter int           W       = 8,
  parameter logic [W-1:0] PATTERN = 8'hF6,
  parameter int           RUN     = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] win_i,
  input  logic         oof_i,
  output logic         lock_o,
  output logic         hunting_o
);
  localparam int PW = (W > 1) ? $clog2(W) : 1;
  localparam int CW = $clog2(RUN + 1);
  localparam logic [CW-1:0] LAST = CW'(RUN - 1);
  localparam logic [PW-1:0] PMAX = PW'(W - 1);

  hunt_state_e   state_q;
  logic          oof_q;
  logic [PW-1:0] pos_q;
  logic [CW-1:0] cnt_q [W];
  logic [CW-1:0] cnt_cur;
  logic          match;
  logic          start;
  logic          active;

  assign match  = (win_i == PATTERN);
  assign start  = oof_i && !oof_q;
  assign active = (state_q == HS_HUNT) && oof_i;

  always_comb begin
    cnt_cur = '0;
    for (int i = 0; i < W; i++) begin
      if (pos_q == PW'(i)) cnt_cur = cnt_q[i];
    end
  end

  assign lock_o    = active && match && (cnt_cur == LAST);
  assign hunting_o = (state_q == HS_HUNT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= HS_TRACK;
      oof_q   <= 1'b0;
      pos_q   <= '0;
    end else begin
      oof_q <= oof_i;
      pos_q <= (pos_q == PMAX) ? '0 : pos_q + 1'b1;
      if (!oof_i)      state_q <= HS_TRACK;
      else if (start)  state_q <= HS_HUNT;
      else if (lock_o) state_q <= HS_TRACK;
    end
  end

  // one run counter per bit phase
  for (genvar g = 0; g < W; g++) begin : g_phase
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                cnt_q[g] <= '0;
      else if (!active || lock_o) cnt_q[g] <= '0;
      else if (pos_q == PW'(g))   cnt_q[g] <= match ? cnt_q[g] + 1'b1 : '0;
    end
  end
endmodule

// File: rtl/fba_byte_framer.sv
module fba_byte_framer #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] win_i,
  input  logic         realign_i,
  output logic [W-1:0] data_o,
  output logic         strb_o
);
  localparam int PW = (W > 1) ? $clog2(W) : 1;
  localparam logic [PW-1:0] PMAX = PW'(W - 1);

  logic [PW-1:0] phase_q;
  logic          wrap;

  assign wrap = (phase_q == PMAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
      data_o  <= '0;
      strb_o  <= 1'b0;
    end else begin
      strb_o <= wrap;
      if (wrap) data_o <= win_i;
      // realign: next word starts with the bit after this edge
      if (realign_i || wrap) phase_q <= '0;
      else                   phase_q <= phase_q + 1'b1;
    end
  end
endmodule

// File: rtl/frame_byte_aligner.sv
module frame_byte_aligner #(
  parameter int                BYTE_W    = 8,
  parameter logic [BYTE_W-1:0] SYNC_BYTE = 8'hF6,
  parameter int                SYNC_RUN  = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sdata_i,
  input  logic              oof_i,
  input  logic              oe_i,
  output logic [BYTE_W-1:0] pdata_o,
  output logic              pstrb_o,
  output logic              hunting_o
);
  logic [BYTE_W-1:0] win;
  logic [BYTE_W-1:0] word_q;
  logic              strb_raw;
  logic              lock_evt;

  fba_shift_window #(.W(BYTE_W)) u_win (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .bit_i  (sdata_i),
    .win_o  (win)
  );

  fba_sync_hunter #(
    .W       (BYTE_W),
    .PATTERN (SYNC_BYTE),
    .RUN     (SYNC_RUN)
  ) u_hunt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .win_i     (win),
    .oof_i     (oof_i),
    .lock_o    (lock_evt),
    .hunting_o (hunting_o)
  );

  fba_byte_framer #(.W(BYTE_W)) u_frm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .win_i     (win),
    .realign_i (lock_evt),
    .data_o    (word_q),
    .strb_o    (strb_raw)
  );

  assign pdata_o = oe_i ? word_q : '0;
  assign pstrb_o = oe_i && strb_raw;
endmodule

// File: rtl/fba_checker.sv
module fba_checker #(
  parameter int W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         oof_i,
  input logic         oe_i,
  input logic [W-1:0] pdata_o,
  input logic         pstrb_o,
  input logic         hunting_o,
  input logic         lock_i,
  input logic         strb_i
);
  localparam int GW = $clog2(2 * W + 2);
  localparam logic [GW-1:0] GMAX = {GW{1'b1}};

  logic [GW-1:0] gap_q;
  logic          seen_q;
  logic          lock_seen_q;
  logic          oof_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q       <= '0;
      seen_q      <= 1'b0;
      lock_seen_q <= 1'b0;
      oof_d       <= 1'b0;
    end else begin
      oof_d <= oof_i;
      if (strb_i) begin
        gap_q       <= '0;
        seen_q      <= 1'b1;
        lock_seen_q <= lock_i;
      end else begin
        if (gap_q != GMAX) gap_q <= gap_q + 1'b1;
        if (lock_i) lock_seen_q <= 1'b1;
      end
    end
  end

  assert_oe_gate_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_i |-> (pdata_o == '0) && !pstrb_o);

  assert_strobe_period_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strb_i && seen_q && !lock_seen_q |-> gap_q == GW'(W - 1));

  assert_strobe_gap_max_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q |-> gap_q <= GW'(2 * W - 2));

  assert_hunt_start_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hunting_o) |-> $past(oof_i) && !$past(oof_d));

  assert_lock_in_hunt_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_i |-> hunting_o && oof_i);

  assert_lock_ends_hunt_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_i |=> !hunting_o);

  assert_hunt_stop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hunting_o) |-> $past(lock_i) || !$past(oof_i));

  assert_no_rehunt_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hunting_o && oof_i && oof_d |=> !hunting_o);
endmodule

bind frame_byte_aligner fba_checker #(.W(BYTE_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .oof_i     (oof_i),
  .oe_i      (oe_i),
  .pdata_o   (pdata_o),
  .pstrb_o   (pstrb_o),
  .hunting_o (hunting_o),
  .lock_i    (lock_evt),
  .strb_i    (strb_raw)
);

// File: tb/frame_byte_aligner_bench.sv
module frame_byte_aligner_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       sdata_i = 1'b0;
  logic       oof_i = 1'b0;
  logic       oe_i = 1'b1;
  logic [7:0] pdata_o;
  logic       pstrb_o;
  logic       hunting_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int       cyc = 0;
  logic [7:0] cap [0:255];
  int       cap_n = 0;
  int       irr_n = 0;
  int       oe_bad = 0;
  bit       have_prev = 1'b0;
  int       prev_cyc = 0;

  frame_byte_aligner u_frame_byte_aligner (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sdata_i   (sdata_i),
    .oof_i     (oof_i),
    .oe_i      (oe_i),
    .pdata_o   (pdata_o),
    .pstrb_o   (pstrb_o),
    .hunting_o (hunting_o)
  );

  always #10 clk_i = ~clk_i;

  always @(posedge clk_i) cyc <= cyc + 1;

  always @(negedge clk_i) begin
    if (!oe_i && (pstrb_o || pdata_o != 8'h00)) oe_bad++;
    if (rst_ni && pstrb_o) begin
      if (cap_n < 256) cap[cap_n] = pdata_o;
      cap_n++;
      if (have_prev && (cyc - prev_cyc) != 8) irr_n++;
      prev_cyc  = cyc;
      have_prev = 1'b1;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic clear_log();
    cap_n     = 0;
    irr_n     = 0;
    oe_bad    = 0;
    have_prev = 1'b0;
  endtask

  task automatic send_bit(input logic b);
    sdata_i = b;
    @(negedge clk_i);
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
  endtask

  task automatic send_zeros(input int n);
    for (int i = 0; i < n; i++) send_bit(1'b0);
  endtask

  task automatic send_run(input int n);
    for (int i = 0; i < n; i++) send_byte(8'hF6);
  endtask

  function automatic int last(input int k);
    if (cap_n - 1 - k < 0) return -1;
    return cap[cap_n - 1 - k];
  endfunction

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R9 reset state
    chk(pdata_o == 8'h00 && !pstrb_o && !hunting_o, "R9 reset outputs",
        {pdata_o, pstrb_o, hunting_o}, 0);
    clear_log();
    rst_ni = 1'b1;

    // R1 MSB-first assembly from reset phase
    send_byte(8'h3A);
    send_byte(8'hC5);
    #1;
    chk(cap_n == 2, "R1 strobe count", cap_n, 2);
    chk(last(1) == 8'h3A, "R1 first word", last(1), 8'h3A);
    chk(last(0) == 8'hC5, "R1 second word", last(0), 8'hC5);
    chk(irr_n == 0, "R2 steady period", irr_n, 0);

    // R3/R4 sweep of framing run over every bit offset
    for (int k = 0; k < 8; k++) begin
      oof_i = 1'b0;
      send_byte(8'h00);
      oof_i = 1'b1;
      send_bit(1'b0);
      #1;
      chk(hunting_o == 1'b1, "R3 hunt starts", hunting_o, 1);
      clear_log();
      send_zeros(7 + k);
      send_run(12);
      #1;
      chk(hunting_o == 1'b0, "R4 hunt ends at lock", hunting_o, 0);
      send_byte(8'h28);
      send_byte(8'h28);
      send_byte(8'h5A);
      #1;
      chk(last(2) == 8'h28 && last(1) == 8'h28 && last(0) == 8'h5A,
          "R4 words after run", last(2), 8'h28);
      chk(irr_n == ((k == 0) ? 0 : 1), "R2 realign interval", irr_n, (k == 0) ? 0 : 1);
    end

    // R7 out-of-frame held high after lock: foreign run ignored
    clear_log();
    send_zeros(3);
    send_run(12);
    send_zeros(5);
    send_byte(8'hA5);
    send_byte(8'h3C);
    #1;
    chk(hunting_o == 1'b0, "R7 no rehunt", hunting_o, 0);
    chk(last(1) == 8'hA5 && last(0) == 8'h3C, "R7 boundary kept", last(1), 8'hA5);
    chk(irr_n == 0, "R7 period unchanged", irr_n, 0);

    // R6 out-of-frame low: foreign run ignored
    oof_i = 1'b0;
    clear_log();
    send_zeros(6);
    send_run(12);
    send_zeros(2);
    send_byte(8'hA5);
    send_byte(8'h3C);
    #1;
    chk(hunting_o == 1'b0, "R6 no hunt while low", hunting_o, 0);
    chk(last(1) == 8'hA5 && last(0) == 8'h3C, "R6 boundary kept", last(1), 8'hA5);
    chk(irr_n == 0, "R6 period unchanged", irr_n, 0);

    // R5 eleven framing bytes then a break do not lock
    send_byte(8'h00);
    oof_i = 1'b1;
    send_byte(8'h00);
    send_zeros(2);
    send_run(11);
    send_byte(8'h00);
    #1;
    chk(hunting_o == 1'b1, "R5 short run no lock", hunting_o, 1);
    send_run(12);
    #1;
    chk(hunting_o == 1'b0, "R5 full run locks", hunting_o, 0);
    send_byte(8'h28);
    send_byte(8'h5A);
    #1;
    chk(last(1) == 8'h28 && last(0) == 8'h5A, "R5 aligned after full run", last(1), 8'h28);

    // R6 hunt abandoned when out-of-frame drops mid-run
    oof_i = 1'b0;
    send_byte(8'h00);
    oof_i = 1'b1;
    send_byte(8'h00);
    send_zeros(4);
    send_run(6);
    oof_i = 1'b0;
    send_run(6);
    #1;
    chk(hunting_o == 1'b0, "R6 hunt abandoned", hunting_o, 0);
    send_zeros(4);
    send_byte(8'hA5);
    #1;
    chk(last(0) == 8'hA5, "R6 boundary after abandon", last(0), 8'hA5);

    // R8 output enable gating
    clear_log();
    oe_i = 1'b0;
    send_byte(8'h11);
    send_byte(8'h22);
    #1;
    chk(oe_bad == 0, "R8 gated outputs zero", oe_bad, 0);
    chk(cap_n == 0, "R8 no strobe while gated", cap_n, 0);
    oe_i = 1'b1;
    send_byte(8'hC3);
    #1;
    chk(cap_n == 1 && last(0) == 8'hC3, "R8 timing kept", last(0), 8'hC3);

    // R9 reset in mid-word
    oof_i = 1'b1;
    send_bit(1'b1);
    #1;
    chk(hunting_o == 1'b1, "R3 hunt before reset", hunting_o, 1);
    send_zeros(2);
    rst_ni = 1'b0;
    #1;
    chk(pdata_o == 8'h00 && !pstrb_o && !hunting_o, "R9 async clear",
        {pdata_o, pstrb_o, hunting_o}, 0);
    oof_i = 1'b0;
    @(negedge clk_i);
    clear_log();
    rst_ni = 1'b1;
    send_byte(8'h81);
    send_byte(8'h7E);
    #1;
    chk(cap_n == 2 && last(1) == 8'h81 && last(0) == 8'h7E, "R9 phase restart",
        last(1), 8'h81);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule